// File: doc/BRIEF.md
# Load/Store Byte-Lane Formatter

This block sits between the execute stage of a 32-bit byte-addressed core and its data memory port. Each request carries a base register value, a signed 16-bit displacement, an access size, an extension mode and, for stores, the source register value. The block adds the base and the sign-extended displacement to form the effective address. It checks the address against the alignment rule for the size, then issues a registered memory request. That request carries a word address, per-lane byte enables and lane-replicated write data.

Byte lanes are big-endian: the byte at offset 0 of a word sits on data bits 31:24. When the memory returns a word for a load, the block picks out the addressed byte or halfword, or takes the whole word. It extends the result to 32 bits with the sign bit or with zeros, using the context saved from the most recent accepted load. A misaligned request issues nothing to memory. It raises an address-error pulse instead, and holds the effective address that faulted so the trap logic can capture it.

Top module: `mem_lane_fmt`

## Requirements
- R1: The effective address is base plus the sign-extended 16-bit displacement, modulo 2^32. On an accepted request, bits 31:2 of it appear on `mem_waddr` one cycle after `req_valid` is sampled.
- R2: Size code 2'b00 selects a byte access. Its single byte enable is `mem_be[3 - off]`, where off is effective address bits 1:0, so lane 0 is bits 31:24. A byte store puts the source's low 8 bits on all four lanes of `mem_wdata`.
- R3: Size code 2'b01 selects a halfword access. Its enables are 4'b1100 when address bit 1 is 0 and 4'b0011 when it is 1. A halfword store puts the source's low 16 bits on both halves of `mem_wdata`.
- R4: Size codes 2'b10 and 2'b11 select a word access. It drives `mem_be` = 4'b1111, and a word store passes the source value through unchanged.
- R5: A halfword with address bit 0 set, or a word with address bits 1:0 nonzero, is misaligned. One cycle after the request it pulses `addr_err` and holds `mem_req`, `mem_be` and `mem_wdata` at zero. `bad_addr` takes the effective address and keeps it until the next misaligned request.
- R6: An aligned request drives `mem_req` high for one cycle, with `addr_err` low and `mem_we` equal to `req_store`. Loads drive the enables of the lanes they read and zero write data.
- R7: A byte load with `req_zext` = 0 copies the byte's bit 7 into result bits 31:8. With `req_zext` = 1 those bits are zero.
- R8: A halfword load fills result bits 31:16 with the halfword's bit 15 when `req_zext` = 0, and with zeros when it is 1.
- R9: A word load returns the memory word unchanged.
- R10: `ld_valid` pulses one cycle after `mem_rvalid` is sampled. `ld_data` is formatted with the size, lane and extension of the most recent aligned load, so misaligned requests and stores do not alter that context.
- R11: While `rst` is high at a clock edge, every output register clears to zero.
- R12: A cycle with `req_valid` low produces no memory request and no address error in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 00 byte, 01 halfword, 10/11 word |
| req_zext | input | 1 | Load extension: 1 zero, 0 sign |
| req_base | input | 32 | Base register value |
| req_disp | input | 16 | Signed displacement |
| req_sdata | input | 32 | Store source register value |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Memory word returned for a load |
| mem_req | output | 1 | Memory access issued |
| mem_we | output | 1 | Access is a write |
| mem_waddr | output | 30 | Word address (effective address bits 31:2) |
| mem_be | output | 4 | Byte enables, bit 3 = bits 31:24 |
| mem_wdata | output | 32 | Lane-replicated write data |
| addr_err | output | 1 | Misaligned access pulse |
| bad_addr | output | 32 | Last faulting effective address |
| ld_valid | output | 1 | Formatted load result valid |
| ld_data | output | 32 | Extended load result |

## Verification
The bench drives each lane offset for byte and halfword accesses. A design with lanes in the wrong endian order would assert the mirrored enable and pick the wrong byte. Negative displacements, including one that wraps below address zero, would expose an offset that is zero-extended instead of sign-extended. Loads whose top bit is set, run in both extension modes, catch extension that uses the wrong bit or ignores the mode. A good load followed by a misaligned one, with the read data returned only afterwards, catches a design that lets the faulting request overwrite the load context. The bench also checks that `bad_addr` keeps its value across later aligned traffic.

// File: rtl/lsu_fmt_pkg.sv
package lsu_fmt_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_WALT = 2'b11
  } acc_size_e;

  // Alignment rule: halfword needs even address, word needs lane 0.
  function automatic logic misaligned(input acc_size_e sz, input logic [1:0] lo);
    case (sz)
      SZ_BYTE: misaligned = 1'b0;
      SZ_HALF: misaligned = lo[0];
      default: misaligned = |lo;
    endcase
  endfunction

endpackage

// File: rtl/lsu_ea_calc.sv
module lsu_ea_calc #(
  parameter int AW = 32,
  parameter int OW = 16
) (
  input  logic [AW-1:0] base,
  input  logic [OW-1:0] disp,
  output logic [AW-1:0] ea
);
  localparam int EXT = AW - OW;

  always_comb begin
    ea = base + {{EXT{disp[OW-1]}}, disp};
  end
endmodule

// File: rtl/lsu_store_lanes.sv
module lsu_store_lanes
  import lsu_fmt_pkg::*;
#(
  parameter int DW = 32
) (
  input  acc_size_e                    size,
  input  logic [$clog2(DW/8)-1:0]      lane,
  input  logic [DW-1:0]                sdata,
  output logic [DW/8-1:0]              be,
  output logic [DW-1:0]                wdata
);
  localparam int LANES = DW / 8;
  localparam int LB    = $clog2(LANES);

  logic [DW/8-1:0] be_byte, be_half;

  // Big-endian: lane i drives enable bit LANES-1-i.
  generate
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign be_byte[LANES-1-i] = (lane == LB'(i));
      assign be_half[LANES-1-i] = (lane[LB-1:1] == (LB-1)'(i / 2));
    end
  endgenerate

  always_comb begin
    case (size)
      SZ_BYTE: begin
        be    = be_byte;
        wdata = {LANES{sdata[7:0]}};
      end
      SZ_HALF: begin
        be    = be_half;
        wdata = {(LANES/2){sdata[15:0]}};
      end
      default: begin
        be    = '1;
        wdata = sdata;
      end
    endcase
  end
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
  import lsu_fmt_pkg::*;
#(
  parameter int DW = 32
) (
  input  acc_size_e                    size,
  input  logic [$clog2(DW/8)-1:0]      lane,
  input  logic                         zext,
  input  logic [DW-1:0]                rdata,
  output logic [DW-1:0]                data
);
  localparam int LANES = DW / 8;
  localparam int LB    = $clog2(LANES);

  logic [7:0]    lane_byte [LANES];
  logic [7:0]    b_sel;
  logic [15:0]   h_sel;
  logic [LB-1:0] h_lo;

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_split
      assign lane_byte[i] = rdata[DW-1-8*i -: 8];
    end
  endgenerate

  always_comb begin
    h_lo  = lane | LB'(1);
    b_sel = lane_byte[lane];
    h_sel = {lane_byte[{lane[LB-1:1], 1'b0}], lane_byte[h_lo]};
    case (size)
      SZ_BYTE: data = {{(DW-8){~zext & b_sel[7]}}, b_sel};
      SZ_HALF: data = {{(DW-16){~zext & h_sel[15]}}, h_sel};
      default: data = rdata;
    endcase
  end
endmodule

// File: rtl/mem_lane_fmt.sv
module mem_lane_fmt
  import lsu_fmt_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int OW = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic                 req_store,
  input  logic [1:0]           req_size,
  input  logic                 req_zext,
  input  logic [AW-1:0]        req_base,
  input  logic [OW-1:0]        req_disp,
  input  logic [DW-1:0]        req_sdata,
  input  logic                 mem_rvalid,
  input  logic [DW-1:0]        mem_rdata,
  output logic                 mem_req,
  output logic                 mem_we,
  output logic [AW-3:0]        mem_waddr,
  output logic [DW/8-1:0]      mem_be,
  output logic [DW-1:0]        mem_wdata,
  output logic                 addr_err,
  output logic [AW-1:0]        bad_addr,
  output logic                 ld_valid,
  output logic [DW-1:0]        ld_data
);
  localparam int LANES = DW / 8;
  localparam int LB    = $clog2(LANES);

  acc_size_e       size_c;
  logic [AW-1:0]   ea;
  logic [LB-1:0]   lane_c;
  logic            mis_c, go_c;
  logic [LANES-1:0] be_c;
  logic [DW-1:0]   wdata_c, ext_c;

  acc_size_e       ctx_size;
  logic [LB-1:0]   ctx_lane;
  logic            ctx_zext;

  assign size_c = acc_size_e'(req_size);
  assign lane_c = ea[LB-1:0];
  assign mis_c  = misaligned(size_c, 2'(ea[1:0]));
  assign go_c   = req_valid & ~mis_c;

  lsu_ea_calc #(.AW(AW), .OW(OW)) u_ea (
    .base (req_base),
    .disp (req_disp),
    .ea   (ea)
  );

  lsu_store_lanes #(.DW(DW)) u_st (
    .size  (size_c),
    .lane  (lane_c),
    .sdata (req_sdata),
    .be    (be_c),
    .wdata (wdata_c)
  );

  lsu_load_extract #(.DW(DW)) u_ld (
    .size  (ctx_size),
    .lane  (ctx_lane),
    .zext  (ctx_zext),
    .rdata (mem_rdata),
    .data  (ext_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_waddr <= '0;
      mem_be    <= '0;
      mem_wdata <= '0;
      addr_err  <= 1'b0;
      bad_addr  <= '0;
      ld_valid  <= 1'b0;
      ld_data   <= '0;
      ctx_size  <= SZ_WORD;
      ctx_lane  <= '0;
      ctx_zext  <= 1'b0;
    end else begin
      mem_req   <= go_c;
      mem_we    <= go_c & req_store;
      mem_waddr <= go_c ? ea[AW-1:2] : '0;
      mem_be    <= go_c ? be_c : '0;
      mem_wdata <= (go_c & req_store) ? wdata_c : '0;
      addr_err  <= req_valid & mis_c;
      if (req_valid && mis_c) bad_addr <= ea;
      if (go_c && !req_store) begin
        ctx_size <= size_c;
        ctx_lane <= lane_c;
        ctx_zext <= req_zext;
      end
      ld_valid <= mem_rvalid;
      if (mem_rvalid) ld_data <= ext_c;
    end
  end

  AST_ERR_BLOCKS_ACCESS: assert property (@(posedge clk) disable iff (rst)
    addr_err |-> (mem_be == '0) && !mem_req && !mem_we);                  // R5
  AST_ERR_FROM_REQUEST: assert property (@(posedge clk) disable iff (rst)
    addr_err |-> $past(req_valid));                                       // R5
  AST_REQ_FROM_VALID: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> $past(req_valid) && !addr_err);                           // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !mem_req && !addr_err);                                // R12
  AST_BE_SHAPE: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> ($countones(mem_be) == 1) || (mem_be == 4'b1100) ||
                (mem_be == 4'b0011) || (mem_be == 4'b1111));              // R3
  AST_WE_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> mem_req && (mem_be != '0));                                // R6
  AST_LD_PULSE: assert property (@(posedge clk) disable iff (rst)
    ld_valid |-> $past(mem_rvalid));                                      // R10
  AST_BYTE_ZEXT: assert property (@(posedge clk) disable iff (rst)
    ld_valid && $past(ctx_size == SZ_BYTE && ctx_zext)
      |-> ld_data[DW-1:8] == '0);                                         // R7
  AST_BAD_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !addr_err |-> $stable(bad_addr));                                     // R5
endmodule

// File: tb/mem_lane_fmt_tb.sv
module mem_lane_fmt_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 18;

  typedef struct packed {
    logic        st;
    logic [1:0]  sz;
    logic        zx;
    logic [31:0] base;
    logic [15:0] disp;
    logic [31:0] sd;
    logic [31:0] rd;
    logic [3:0]  be;
    logic [31:0] wd;
    logic        err;
    logic [31:0] ld;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{1'b1, 2'd0, 1'b0, 32'h0000_1000, 16'h0001, 32'h1234_56AB, 32'h0, 4'b0100, 32'hABAB_ABAB, 1'b0, 32'h0},
    '{1'b1, 2'd0, 1'b0, 32'h0000_2000, 16'h0003, 32'h1234_56AB, 32'h0, 4'b0001, 32'hABAB_ABAB, 1'b0, 32'h0},
    '{1'b1, 2'd1, 1'b0, 32'h0000_3000, 16'h0002, 32'hDEAD_BEEF, 32'h0, 4'b0011, 32'hBEEF_BEEF, 1'b0, 32'h0},
    '{1'b1, 2'd1, 1'b0, 32'h0000_3004, 16'hFFFC, 32'hDEAD_BEEF, 32'h0, 4'b1100, 32'hBEEF_BEEF, 1'b0, 32'h0},
    '{1'b1, 2'd2, 1'b0, 32'h0000_0010, 16'h0004, 32'hCAFE_F00D, 32'h0, 4'b1111, 32'hCAFE_F00D, 1'b0, 32'h0},
    '{1'b1, 2'd1, 1'b0, 32'h0000_4000, 16'h0001, 32'h1111_2222, 32'h0, 4'b0000, 32'h0,         1'b1, 32'h0},
    '{1'b1, 2'd2, 1'b0, 32'h0000_5000, 16'h0002, 32'h3333_4444, 32'h0, 4'b0000, 32'h0,         1'b1, 32'h0},
    '{1'b0, 2'd0, 1'b0, 32'h0000_0100, 16'h0000, 32'h0, 32'h8011_2233, 4'b1000, 32'h0, 1'b0, 32'hFFFF_FF80},
    '{1'b0, 2'd0, 1'b1, 32'h0000_0100, 16'h0000, 32'h0, 32'h8011_2233, 4'b1000, 32'h0, 1'b0, 32'h0000_0080},
    '{1'b0, 2'd0, 1'b0, 32'h0000_0100, 16'h0002, 32'h0, 32'h8011_2233, 4'b0010, 32'h0, 1'b0, 32'h0000_0022},
    '{1'b0, 2'd1, 1'b0, 32'h0000_0100, 16'h0002, 32'h0, 32'h1234_F00D, 4'b0011, 32'h0, 1'b0, 32'hFFFF_F00D},
    '{1'b0, 2'd1, 1'b1, 32'h0000_0100, 16'h0002, 32'h0, 32'h1234_F00D, 4'b0011, 32'h0, 1'b0, 32'h0000_F00D},
    '{1'b0, 2'd1, 1'b0, 32'h0000_0104, 16'hFFFC, 32'h0, 32'h8001_0000, 4'b1100, 32'h0, 1'b0, 32'hFFFF_8001},
    '{1'b0, 2'd2, 1'b0, 32'h0000_0200, 16'h0000, 32'h0, 32'h89AB_CDEF, 4'b1111, 32'h0, 1'b0, 32'h89AB_CDEF},
    '{1'b0, 2'd2, 1'b0, 32'h0000_0200, 16'h0003, 32'h0, 32'h0,         4'b0000, 32'h0, 1'b1, 32'h0},
    '{1'b0, 2'd3, 1'b0, 32'h0000_0300, 16'h0000, 32'h0, 32'h0102_0304, 4'b1111, 32'h0, 1'b0, 32'h0102_0304},
    '{1'b0, 2'd0, 1'b1, 32'h0000_0000, 16'hFFFF, 32'h0, 32'hAABB_CCDD, 4'b0001, 32'h0, 1'b0, 32'h0000_00DD},
    '{1'b0, 2'd0, 1'b0, 32'h0000_0800, 16'h0003, 32'h0, 32'h0000_00F0, 4'b0001, 32'h0, 1'b0, 32'hFFFF_FFF0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_store = 1'b0, req_zext = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [31:0] req_base = '0, req_sdata = '0, mem_rdata = '0;
  logic [15:0] req_disp = '0;
  logic        mem_rvalid = 1'b0;
  logic        mem_req, mem_we, addr_err, ld_valid;
  logic [29:0] mem_waddr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata, bad_addr, ld_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_lane_fmt u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_store(req_store),
    .req_size(req_size), .req_zext(req_zext), .req_base(req_base),
    .req_disp(req_disp), .req_sdata(req_sdata), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_waddr(mem_waddr), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .addr_err(addr_err), .bad_addr(bad_addr), .ld_valid(ld_valid),
    .ld_data(ld_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic st, input logic [1:0] sz, input logic zx,
                       input logic [31:0] base, input logic [15:0] disp,
                       input logic [31:0] sd);
    @(negedge clk);
    req_valid = 1'b1; req_store = st; req_size = sz; req_zext = zx;
    req_base = base; req_disp = disp; req_sdata = sd;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic ret_data(input logic [31:0] rd);
    mem_rvalid = 1'b1; mem_rdata = rd;
    @(negedge clk);
    mem_rvalid = 1'b0;
  endtask

  task automatic run_vec(input vec_t v);
    logic [31:0] ea;
    string bt, lt;
    ea = v.base + {{16{v.disp[15]}}, v.disp};
    bt = (v.sz == 2'd0) ? "R2 be/wdata" : (v.sz == 2'd1) ? "R3 be/wdata" : "R4 be/wdata";
    lt = (v.sz == 2'd0) ? "R7 byte load" : (v.sz == 2'd1) ? "R8 half load" : "R9 word load";
    issue(v.st, v.sz, v.zx, v.base, v.disp, v.sd);
    chk("R5 addr_err", 32'(addr_err), 32'(v.err));
    chk(bt, 32'(mem_be), 32'(v.be));
    chk(bt, mem_wdata, v.wd);
    if (v.err) begin
      chk("R5 bad_addr", bad_addr, ea);
      chk("R5 mem_req", 32'(mem_req), 32'd0);
    end else begin
      chk("R6 mem_req", 32'(mem_req), 32'd1);
      chk("R6 mem_we", 32'(mem_we), 32'(v.st));
      chk("R1 mem_waddr", 32'(mem_waddr), 32'(ea[31:2]));
      if (!v.st) begin
        ret_data(v.rd);
        chk("R10 ld_valid", 32'(ld_valid), 32'd1);
        chk(lt, ld_data, v.ld);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 mem_req", 32'(mem_req), 32'd0);
    chk("R11 mem_be", 32'(mem_be), 32'd0);
    chk("R11 addr_err", 32'(addr_err), 32'd0);
    chk("R11 bad_addr", bad_addr, 32'd0);
    chk("R11 ld_valid", 32'(ld_valid), 32'd0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R12: idle cycle and R10: single-cycle load pulse
    @(negedge clk);
    chk("R12 idle mem_req", 32'(mem_req), 32'd0);
    chk("R12 idle addr_err", 32'(addr_err), 32'd0);
    chk("R10 ld_valid pulse", 32'(ld_valid), 32'd0);

    // R10: misaligned load between accept and data must not disturb context
    issue(1'b0, 2'd0, 1'b1, 32'h0000_0040, 16'h0001, 32'h0);
    chk("R2 byte be lane1", 32'(mem_be), 32'h4);
    issue(1'b0, 2'd1, 1'b0, 32'h0000_0040, 16'h0001, 32'h0);
    chk("R5 err on odd half", 32'(addr_err), 32'd1);
    chk("R5 bad_addr", bad_addr, 32'h0000_0041);
    ret_data(32'h11F2_3344);
    chk("R10 context kept", ld_data, 32'h0000_00F2);

    // R5: bad_addr holds over aligned traffic; a store does not touch load context
    issue(1'b1, 2'd2, 1'b0, 32'h0000_0080, 16'h0000, 32'h5555_AAAA);
    chk("R4 word store", mem_wdata, 32'h5555_AAAA);
    chk("R5 bad_addr held", bad_addr, 32'h0000_0041);
    ret_data(32'h00F2_0000);
    chk("R10 store leaves context", ld_data, 32'h0000_00F2);

    // R11: reset clears after activity
    issue(1'b1, 2'd1, 1'b0, 32'h0000_0000, 16'h0003, 32'h0);
    rst = 1'b1;
    @(negedge clk);
    chk("R11 addr_err after rst", 32'(addr_err), 32'd0);
    chk("R11 bad_addr after rst", bad_addr, 32'd0);
    rst = 1'b0;

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule